// File: doc/BRIEF.md
# Stack Machine Data Path

This block is the data-handling half of a small stack processor that uses 9-bit opcodes and 8-bit data. The operand stack sits in three layers: a top register, a second register just beneath it, and a circular store of configurable depth below that. On each clock edge where the opcode strobe is high, the block decodes the opcode and updates the top value, the second value and the stack pointer. Tests do not set condition codes. Instead they leave a 0xFF or 0x00 flag on the stack for the sequencer to consume.

The supported operations are literal pushes, one-bit shifts and rotates, compare-to-flag, add and subtract, bitwise logic, stack reshuffles, increment and decrement, and transfers between the top value and a return-value input. The top and second values are driven straight to neighbouring units. These units (sequencer, memory banks, I/O) can read both values, and can use the pop this block performs for their own instructions. The store moves by at most one position per instruction. It wraps around its ends without faulting, and two sticky status bits record whether it ever overflowed or underflowed.

Top module: `sdp_core`

## Requirements
- R1: After reset, the top value, the second value and both sticky status bits read zero, and the store holds zeros.
- R2: An opcode with bit 8 set loads its bits 7:0 into the top value, moves the old top value into the second value, and pushes the old second value into the store.
- R3: Opcodes 0x000 to 0x007 change only the top value. 0x000 keeps it. 0x001 shifts left and brings in 0. 0x002 shifts left and brings in 1. 0x003 shifts left and rotates bit 7 into bit 0. 0x004 shifts right and brings in 0. 0x005 shifts right and brings in 1. 0x006 shifts right and keeps bit 7. 0x007 shifts right and rotates bit 0 into bit 7.
- R4: Each compare opcode replaces the top value with 0xFF when its test holds and with 0x00 otherwise, and leaves the second value and the store alone. 0x020 tests for zero, 0x021 for non-zero, 0x022 for all ones and 0x023 for not all ones.
- R5: 0x018 leaves (second + top) mod 256 in the top value and 0x01C leaves (second − top) mod 256. Both pop the store once into the second value.
- R6: 0x050 (AND), 0x051 (OR) and 0x052 (XOR) leave second op top in the top value and pop the store once into the second value.
- R7: 0x053 keeps the top value and pops the store into the second value. 0x054 moves the second value into the top value and pops the store. 0x012 exchanges the top and second values without moving the store.
- R8: 0x008 copies the top value into the second value. 0x00A writes the old second value into the top value and the old top value into the second value. Both push the old second value into the store.
- R9: 0x058 adds 1 to the top value and 0x05C subtracts 1, both modulo 256. The second value and the store are unchanged.
- R10: 0x009 and 0x049 load the return-value input into the top value, move the old top value into the second value and push the old second value. 0x040 moves the second value into the top value and pops the store.
- R11: The store pointer wraps at both ends. A push while all DEPTH entries are occupied sets the overflow bit, and a pop while no entry is occupied sets the underflow bit. Both bits stay set until reset.
- R12: An opcode not listed above, or any opcode presented with the strobe low, leaves the top value, the second value, the store and the status bits unchanged.
- R13: Every instruction moves the store by at most one position, so popped entries come back in reverse push order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Opcode strobe; the opcode executes on this edge |
| op_code | input | 9 | Instruction word |
| ret_val | input | 8 | Value from the return stack, used by the transfer opcodes |
| top_o | output | 8 | Current top value |
| next_o | output | 8 | Current second value |
| ovf_o | output | 1 | Sticky overflow status |
| unf_o | output | 1 | Sticky underflow status |

## Verification
Every result is registered, so the top value, the second value and both status bits reflect an opcode one clock edge after it is presented. A value popped into the second value comes from the store through a combinational read and is visible in that same cycle. The bench presents each opcode on a falling edge and compares all four outputs with a behavioural stack model on the next falling edge, one full cycle later. No check samples on the edge where the outputs change. The overflow and underflow scenarios start from a fresh reset, so the cycle in which each sticky bit first rises is known exactly.

// File: rtl/sdp_pkg.sv
package sdp_pkg;
    localparam int DW  = 8;
    localparam int OPW = 9;

    // Opcode values decoded by neighbouring units; positions are fixed.
    localparam logic [OPW-1:0] OP_DUP   = 9'h008;
    localparam logic [OPW-1:0] OP_RCOPY = 9'h009;
    localparam logic [OPW-1:0] OP_OVER  = 9'h00A;
    localparam logic [OPW-1:0] OP_SWAP  = 9'h012;
    localparam logic [OPW-1:0] OP_ADD   = 9'h018;
    localparam logic [OPW-1:0] OP_SUB   = 9'h01C;
    localparam logic [OPW-1:0] OP_ISZ   = 9'h020;
    localparam logic [OPW-1:0] OP_NZ    = 9'h021;
    localparam logic [OPW-1:0] OP_ISONE = 9'h022;
    localparam logic [OPW-1:0] OP_NONE1 = 9'h023;
    localparam logic [OPW-1:0] OP_TOR   = 9'h040;
    localparam logic [OPW-1:0] OP_RFROM = 9'h049;
    localparam logic [OPW-1:0] OP_AND   = 9'h050;
    localparam logic [OPW-1:0] OP_OR    = 9'h051;
    localparam logic [OPW-1:0] OP_XOR   = 9'h052;
    localparam logic [OPW-1:0] OP_NIP   = 9'h053;
    localparam logic [OPW-1:0] OP_DROP  = 9'h054;
    localparam logic [OPW-1:0] OP_INC   = 9'h058;
    localparam logic [OPW-1:0] OP_DEC   = 9'h05C;

    typedef enum logic [1:0] {MV_HOLD, MV_PUSH, MV_POP} move_e;
    typedef enum logic [1:0] {NS_KEEP, NS_TOP, NS_STACK} nsel_e;

    typedef struct packed {
        logic [DW-1:0] t;
        nsel_e         nsel;
        move_e         move;
    } dec_t;

    typedef struct packed {
        logic [DW-1:0] t;
        logic [DW-1:0] n;
    } tn_t;
endpackage

// File: rtl/sdp_decode.sv
module sdp_decode
    import sdp_pkg::*;
(
    input  logic           valid,
    input  logic [OPW-1:0] op,
    input  logic [DW-1:0]  t,
    input  logic [DW-1:0]  n,
    input  logic [DW-1:0]  ret,
    output dec_t           dec
);
    always_comb begin
        dec      = '{t: t, nsel: NS_KEEP, move: MV_HOLD};
        if (valid) begin
            if (op[OPW-1]) begin
                dec = '{t: op[DW-1:0], nsel: NS_TOP, move: MV_PUSH};
            end else begin
                unique case (op)
                    9'h000:   dec.t = t;
                    9'h001:   dec.t = {t[DW-2:0], 1'b0};
                    9'h002:   dec.t = {t[DW-2:0], 1'b1};
                    9'h003:   dec.t = {t[DW-2:0], t[DW-1]};
                    9'h004:   dec.t = {1'b0, t[DW-1:1]};
                    9'h005:   dec.t = {1'b1, t[DW-1:1]};
                    9'h006:   dec.t = {t[DW-1], t[DW-1:1]};
                    9'h007:   dec.t = {t[0], t[DW-1:1]};
                    OP_ISZ:   dec.t = {DW{t == '0}};
                    OP_NZ:    dec.t = {DW{t != '0}};
                    OP_ISONE: dec.t = {DW{&t}};
                    OP_NONE1: dec.t = {DW{~&t}};
                    OP_INC:   dec.t = t + 1'b1;
                    OP_DEC:   dec.t = t - 1'b1;
                    OP_SWAP:  dec   = '{t: n, nsel: NS_TOP, move: MV_HOLD};
                    OP_DUP:   dec   = '{t: t, nsel: NS_TOP, move: MV_PUSH};
                    OP_OVER:  dec   = '{t: n, nsel: NS_TOP, move: MV_PUSH};
                    OP_RCOPY,
                    OP_RFROM: dec   = '{t: ret, nsel: NS_TOP, move: MV_PUSH};
                    OP_ADD:   dec   = '{t: n + t, nsel: NS_STACK, move: MV_POP};
                    OP_SUB:   dec   = '{t: n - t, nsel: NS_STACK, move: MV_POP};
                    OP_AND:   dec   = '{t: n & t, nsel: NS_STACK, move: MV_POP};
                    OP_OR:    dec   = '{t: n | t, nsel: NS_STACK, move: MV_POP};
                    OP_XOR:   dec   = '{t: n ^ t, nsel: NS_STACK, move: MV_POP};
                    OP_NIP:   dec   = '{t: t, nsel: NS_STACK, move: MV_POP};
                    OP_DROP,
                    OP_TOR:   dec   = '{t: n, nsel: NS_STACK, move: MV_POP};
                    default:  dec   = '{t: t, nsel: NS_KEEP, move: MV_HOLD};
                endcase
            end
        end
    end
endmodule

// File: rtl/sdp_stack.sv
module sdp_stack
    import sdp_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  move_e         move,
    input  logic [DW-1:0] push_data,
    output logic [DW-1:0] rd_data,
    output logic          ovf,
    output logic          unf
);
    localparam int SPW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int LW  = $clog2(DEPTH + 1);
    localparam logic [LW-1:0] FULL = LW'(DEPTH);

    typedef struct packed {
        logic [SPW-1:0] sp;
        logic [LW-1:0]  lvl;
        logic           ovf;
        logic           unf;
    } stk_t;

    stk_t stk_d, stk_q;
    logic [DW-1:0] mem_q [DEPTH];
    logic [LW-1:0] lvl_q;
    logic [SPW-1:0] wr_idx;

    assign lvl_q   = stk_q.lvl;
    assign wr_idx  = stk_q.sp + 1'b1;
    assign rd_data = mem_q[stk_q.sp];
    assign ovf     = stk_q.ovf;
    assign unf     = stk_q.unf;

    always_comb begin
        stk_d = stk_q;
        unique case (move)
            MV_PUSH: begin
                stk_d.sp = wr_idx;
                if (stk_q.lvl == FULL) stk_d.ovf = 1'b1;
                else                   stk_d.lvl = stk_q.lvl + 1'b1;
            end
            MV_POP: begin
                stk_d.sp = stk_q.sp - 1'b1;
                if (stk_q.lvl == '0) stk_d.unf = 1'b1;
                else                 stk_d.lvl = stk_q.lvl - 1'b1;
            end
            default: stk_d = stk_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) stk_q <= '0;
        else        stk_q <= stk_d;
    end

    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_cell
            always_ff @(posedge clk) begin
                if (!rst_n)
                    mem_q[i] <= '0;
                else if (move == MV_PUSH && wr_idx == SPW'(i))
                    mem_q[i] <= push_data;
            end
        end
    endgenerate
endmodule

// File: rtl/sdp_core.sv
module sdp_core
    import sdp_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           op_valid,
    input  logic [OPW-1:0] op_code,
    input  logic [DW-1:0]  ret_val,
    output logic [DW-1:0]  top_o,
    output logic [DW-1:0]  next_o,
    output logic           ovf_o,
    output logic           unf_o
);
    tn_t           core_d, core_q;
    dec_t          dec;
    logic [DW-1:0] stk_rd;

    sdp_decode u_dec (
        .valid (op_valid),
        .op    (op_code),
        .t     (core_q.t),
        .n     (core_q.n),
        .ret   (ret_val),
        .dec   (dec)
    );

    sdp_stack #(.DEPTH(DEPTH)) u_stack (
        .clk       (clk),
        .rst_n     (rst_n),
        .move      (dec.move),
        .push_data (core_q.n),
        .rd_data   (stk_rd),
        .ovf       (ovf_o),
        .unf       (unf_o)
    );

    always_comb begin
        core_d.t = dec.t;
        unique case (dec.nsel)
            NS_TOP:   core_d.n = core_q.t;
            NS_STACK: core_d.n = stk_rd;
            default:  core_d.n = core_q.n;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) core_q <= '0;
        else        core_q <= core_d;
    end

    assign top_o  = core_q.t;
    assign next_o = core_q.n;
endmodule

// File: rtl/sdp_core_chk.sv
module sdp_core_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       op_valid,
    input logic [8:0] op_code,
    input logic [7:0] top_o,
    input logic [7:0] next_o,
    input logic       ovf_o,
    input logic       unf_o
);
    assert_push_lit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code[8]) |=> (top_o == $past(op_code[7:0]) && next_o == $past(top_o)));

    assert_cmp_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code[8:2] == 7'b0001000) |=> ((top_o == 8'hFF || top_o == 8'h00) && $stable(next_o)));

    assert_swap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 9'h012) |=> (top_o == $past(next_o) && next_o == $past(top_o)));

    assert_no_overflow_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |=> ovf_o);

    assert_no_underflow_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        unf_o |=> unf_o);

    assert_idle_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> ($stable(top_o) && $stable(next_o) && $stable(ovf_o) && $stable(unf_o)));
endmodule

module sdp_stack_chk #(
    parameter int LW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic [LW-1:0] lvl
);
    assert_one_shift_R13: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (lvl == $past(lvl) || lvl == LW'($past(lvl) + 1'b1) || lvl == LW'($past(lvl) - 1'b1)));
endmodule

bind sdp_core sdp_core_chk u_core_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_valid (op_valid),
    .op_code  (op_code),
    .top_o    (top_o),
    .next_o   (next_o),
    .ovf_o    (ovf_o),
    .unf_o    (unf_o)
);

bind sdp_stack sdp_stack_chk #(.LW(LW)) u_stack_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .lvl   (lvl_q)
);

// File: tb/sdp_core_test.sv
module sdp_core_test;
    localparam int DEPTH = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_valid = 1'b0;
    logic [8:0] op_code = '0;
    logic [7:0] ret_val = '0;
    logic [7:0] top_o, next_o;
    logic       ovf_o, unf_o;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  done     = 1'b0;

    // behavioural reference stack
    logic [7:0] m_t, m_n;
    logic [7:0] m_mem [DEPTH];
    int         m_sp, m_lvl;
    bit         m_ovf, m_unf;

    always #10 clk = ~clk;

    sdp_core #(.DEPTH(DEPTH)) uut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .ret_val(ret_val), .top_o(top_o), .next_o(next_o), .ovf_o(ovf_o), .unf_o(unf_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic m_push();
        m_sp = (m_sp + 1) % DEPTH;
        m_mem[m_sp] = m_n;
        if (m_lvl == DEPTH) m_ovf = 1'b1; else m_lvl++;
    endtask

    task automatic m_pop();
        m_n = m_mem[m_sp];
        m_sp = (m_sp + DEPTH - 1) % DEPTH;
        if (m_lvl == 0) m_unf = 1'b1; else m_lvl--;
    endtask

    task automatic model(input bit v, input logic [8:0] op, input logic [7:0] rv);
        logic [7:0] t0, n0;
        t0 = m_t; n0 = m_n;
        if (!v) return;
        if (op[8]) begin m_push(); m_t = op[7:0]; m_n = t0; return; end
        case (op)
            9'h001: m_t = t0 << 1;
            9'h002: m_t = (t0 << 1) | 8'h01;
            9'h003: m_t = (t0 << 1) | (t0 >> 7);
            9'h004: m_t = t0 >> 1;
            9'h005: m_t = (t0 >> 1) | 8'h80;
            9'h006: m_t = (t0 >> 1) | (t0 & 8'h80);
            9'h007: m_t = (t0 >> 1) | (t0 << 7);
            9'h020: m_t = (t0 == 8'h00) ? 8'hFF : 8'h00;
            9'h021: m_t = (t0 != 8'h00) ? 8'hFF : 8'h00;
            9'h022: m_t = (t0 == 8'hFF) ? 8'hFF : 8'h00;
            9'h023: m_t = (t0 != 8'hFF) ? 8'hFF : 8'h00;
            9'h058: m_t = t0 + 8'd1;
            9'h05C: m_t = t0 - 8'd1;
            9'h012: begin m_t = n0; m_n = t0; end
            9'h008: begin m_push(); m_n = t0; end
            9'h00A: begin m_push(); m_t = n0; m_n = t0; end
            9'h009, 9'h049: begin m_push(); m_t = rv; m_n = t0; end
            9'h018: begin m_pop(); m_t = n0 + t0; end
            9'h01C: begin m_pop(); m_t = n0 - t0; end
            9'h050: begin m_pop(); m_t = n0 & t0; end
            9'h051: begin m_pop(); m_t = n0 | t0; end
            9'h052: begin m_pop(); m_t = n0 ^ t0; end
            9'h053: m_pop();
            9'h054, 9'h040: begin m_pop(); m_t = n0; end
            default: ;
        endcase
    endtask

    // present one opcode on a falling edge, compare one cycle later
    task automatic step(input string req, input logic [8:0] op,
                        input bit v = 1'b1, input logic [7:0] rv = 8'h00);
        op_valid = v; op_code = op; ret_val = rv;
        model(v, op, rv);
        @(negedge clk);
        op_valid = 1'b0;
        check({req, " top"},  {24'h0, top_o},  {24'h0, m_t});
        check({req, " next"}, {24'h0, next_o}, {24'h0, m_n});
        check({req, " flags"}, {30'h0, ovf_o, unf_o}, {30'h0, m_ovf, m_unf});
    endtask

    task automatic do_reset();
        rst_n = 1'b0; op_valid = 1'b0;
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        m_t = '0; m_n = '0; m_sp = 0; m_lvl = 0; m_ovf = 0; m_unf = 0;
        for (int i = 0; i < DEPTH; i++) m_mem[i] = '0;
    endtask

    task automatic t_reset_R1();
        do_reset();
        check("R1 top", {24'h0, top_o}, 32'h0);
        check("R1 next", {24'h0, next_o}, 32'h0);
        check("R1 flags", {30'h0, ovf_o, unf_o}, 32'h0);
    endtask

    task automatic t_push_R2();
        do_reset();
        step("R2", 9'h1A5); step("R2", 9'h13C); step("R2", 9'h100); step("R2", 9'h1FF);
        check("R2 literal", {24'h0, top_o}, 32'hFF);
    endtask

    task automatic t_shift_R3();
        do_reset();
        for (int k = 0; k < 8; k++) begin
            step("R3 seed", 9'h196);
            step("R3", 9'(k));
        end
        step("R3 seed", 9'h101); step("R3 lsb rot", 9'h007);
        check("R3 lsb rot value", {24'h0, top_o}, 32'h80);
        step("R3 msb keep", 9'h006);
        check("R3 msb keep value", {24'h0, top_o}, 32'hC0);
    endtask

    task automatic t_cmp_R4();
        logic [7:0] vals [3] = '{8'h00, 8'hFF, 8'h5A};
        do_reset();
        step("R4 base", 9'h177);
        foreach (vals[i])
            for (int c = 0; c < 4; c++) begin
                step("R4 seed", {1'b1, vals[i]});
                step("R4", 9'h020 + 9'(c));
            end
    endtask

    task automatic t_arith_R5();
        do_reset();
        step("R5", 9'h111); step("R5", 9'h110); step("R5", 9'h120); step("R5 sub wrap", 9'h01C);
        check("R5 sub wrap value", {24'h0, top_o}, 32'hF0);
        step("R5", 9'h120); step("R5 add wrap", 9'h018);
        check("R5 add wrap value", {24'h0, top_o}, 32'h10);
    endtask

    task automatic t_logic_R6();
        do_reset();
        for (int k = 0; k < 3; k++) begin
            step("R6", 9'h1C3); step("R6", 9'h1A5); step("R6", 9'h050 + 9'(k));
        end
    endtask

    task automatic t_stackops_R7();
        do_reset();
        step("R7", 9'h111); step("R7", 9'h122); step("R7", 9'h133); step("R7", 9'h144);
        step("R7 swap", 9'h012);
        step("R7 nip", 9'h053);
        step("R13 order", 9'h054);
        check("R13 popped entry", {24'h0, next_o}, 32'h11);
        step("R13 order", 9'h054);
    endtask

    task automatic t_dup_R8();
        do_reset();
        step("R8", 9'h10A); step("R8", 9'h10B);
        step("R8 dup", 9'h008); step("R8 over", 9'h00A);
        step("R8 drop back", 9'h054); step("R8 drop back", 9'h054);
    endtask

    task automatic t_incdec_R9();
        do_reset();
        step("R9", 9'h155); step("R9", 9'h1FF); step("R9 inc wrap", 9'h058);
        check("R9 inc wrap value", {24'h0, top_o}, 32'h00);
        step("R9 dec wrap", 9'h05C);
        check("R9 dec wrap value", {24'h0, top_o}, 32'hFF);
    endtask

    task automatic t_ret_R10();
        do_reset();
        step("R10", 9'h131); step("R10", 9'h132);
        step("R10 copy", 9'h009, 1'b1, 8'hE7);
        step("R10 take", 9'h049, 1'b1, 8'h3D);
        step("R10 give", 9'h040);
        step("R10 give", 9'h040);
    endtask

    task automatic t_wrap_R11();
        do_reset();
        for (int k = 0; k < DEPTH + 2; k++) step("R11 fill", 9'(9'h100 + k));
        check("R11 overflow set", {31'h0, ovf_o}, 32'h1);
        for (int k = 0; k < DEPTH + 3; k++) step("R11 drain", 9'h054);
        check("R11 underflow set", {31'h0, unf_o}, 32'h1);
        step("R11 sticky", 9'h1AA);
        check("R11 flags held", {30'h0, ovf_o, unf_o}, 32'h3);
    endtask

    task automatic t_ignore_R12();
        do_reset();
        step("R12", 9'h1AB); step("R12", 9'h1CD);
        step("R12 idle strobe", 9'h1EE, 1'b0);
        step("R12 undecoded", 9'h0FF);
        step("R12 undecoded", 9'h019);
        step("R12 undecoded", 9'h060);
        step("R12 store intact", 9'h054);
        check("R12 store intact value", {24'h0, next_o}, 32'h00);
    endtask

    initial begin
        @(negedge clk);
        t_reset_R1();
        t_push_R2();
        t_shift_R3();
        t_cmp_R4();
        t_arith_R5();
        t_logic_R6();
        t_stackops_R7();
        t_dup_R8();
        t_incdec_R9();
        t_ret_R10();
        t_wrap_R11();
        t_ignore_R12();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end
endmodule